// File: doc/BRIEF.md
# Fixed-Point Audio DSP Arithmetic Unit

This unit carries out one arithmetic instruction of an audio signal processor each time it is issued. An instruction is a 4-bit opcode with three signed two's-complement operands, A, X and Y. From these the unit forms a result R and a condition word. The opcodes cover several kinds of operation:

- multiply-accumulate in two number formats: fractional, where the product is scaled down by 2^31, and integer;
- the same multiply-accumulate with either a saturating or a wrapping add;
- a three-input saturating add;
- a mask-then-toggle logic operation;
- compare-driven selects;
- linear interpolation;
- a move that passes A through unchanged while adding a fractional product into a private accumulator.

The surrounding sequencer drives a one-cycle issue strobe together with the operands and the program address of the instruction. The result, the condition word and a valid pulse appear one clock later. A sticky saturation record keeps the program address of the first instruction since reset whose result had to be clamped. Operand fetch, register files, delay memory and the logarithm, exponent and skip operations belong to other blocks. Their opcodes, and every other opcode not listed below, return A.

Top module: `fxp_dsp_alu`

## Requirements
- R1: On a clock edge with `issue` high, `res`, `cc` and `acc` take the new values and `res_valid` goes high after that edge. On an edge with `issue` low, `res` and `cc` hold and `res_valid` is low.
- R2: Opcode 4'h0 gives A + F and opcode 4'h1 gives A - F, where F = (X*Y) >>> 31 is formed from the full 64-bit signed product. Both saturate: positive overflow gives 32'h7FFFFFFF and negative overflow gives 32'h80000000.
- R3: Opcodes 4'h2 and 4'h3 give the low 32 bits of A + F and A - F, with no clamping.
- R4: Opcode 4'h4 gives A + X*Y (integer product) with saturation. Opcode 4'h5 keeps the low 31 bits of A + X*Y and copies bit 30 into bit 31.
- R5: Opcode 4'h6 gives A + X + Y with saturation.
- R6: Opcode 4'h7 gives R = A and adds the low 32 bits of F into the 32-bit accumulator `acc`, wrapping on overflow. No other opcode changes `acc`, and reset clears it.
- R7: Opcode 4'h8 gives (A & X) ^ Y. Using signed comparison, 4'h9 gives X if A >= Y and ~X otherwise; 4'hA gives X if A >= Y and Y otherwise; 4'hB gives X if A < Y and Y otherwise.
- R8: Opcode 4'hE gives A + ((X * (Y - A)) >>> 31), computed at full precision, with saturation.
- R9: Opcodes 4'hC, 4'hD and 4'hF give R = A and leave `acc` unchanged.
- R10: Condition word bits:
  - bit 0: R[31] differs from R[30];
  - bit 1: signed A < Y, on opcodes 4'h9 to 4'hB only;
  - bit 2: R[31];
  - bit 3: R is zero;
  - bit 4: the result was clamped;
  - bit 8: R is nonzero;
  - all other bits are zero.
- R11: The first issued instruction that clamps sets `sat_seen` and stores its `instr_pc` in `sat_pc`. Both then hold until reset, whatever later instructions do.
- R12: Reset clears `res`, `cc`, `res_valid`, `acc`, `sat_seen` and `sat_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Executes the presented instruction this cycle |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | Operand A |
| op_x | input | 32 | Operand X |
| op_y | input | 32 | Operand Y |
| instr_pc | input | 9 | Program address of the presented instruction |
| res | output | 32 | Registered result R |
| cc | output | 9 | Registered condition word |
| res_valid | output | 1 | High for one cycle after each issue |
| acc | output | 32 | Accumulator |
| sat_seen | output | 1 | Sticky flag: some instruction has clamped |
| sat_pc | output | 9 | Address of the first clamping instruction |

## Verification
The assertions watch, on every cycle:
- the issue-to-valid timing and that results hold on idle cycles;
- that a set saturate flag always comes with one of the two clamp values;
- that the zero and nonzero flags agree with the result;
- that the accumulator moves only on the accumulate opcode;
- that the saturation record is captured once and then stays frozen.

Whether each opcode computes the right value can only be shown by the bench's scenarios. These include fractional rounding of extreme products, the 31-bit wrap, signed compares across the sign boundary, interpolation overflow and accumulator wrap.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

  typedef enum logic [3:0] {
    OP_MACF   = 4'h0,
    OP_MACFN  = 4'h1,
    OP_MACFW  = 4'h2,
    OP_MACFNW = 4'h3,
    OP_MACI   = 4'h4,
    OP_MACIW  = 4'h5,
    OP_ADD3   = 4'h6,
    OP_MOVACC = 4'h7,
    OP_MASKX  = 4'h8,
    OP_TSTINV = 4'h9,
    OP_SELGE  = 4'hA,
    OP_SELLT  = 4'hB,
    OP_RSV_C  = 4'hC,
    OP_RSV_D  = 4'hD,
    OP_INTERP = 4'hE,
    OP_RSV_F  = 4'hF
  } fx_op_e;

  localparam int CCW       = 9;
  localparam int CC_NORM   = 0;
  localparam int CC_BORROW = 1;
  localparam int CC_MINUS  = 2;
  localparam int CC_ZERO   = 3;
  localparam int CC_SAT    = 4;
  localparam int CC_NZ     = 8;

endpackage

// File: rtl/fxp_arith.sv
module fxp_arith
  import fxp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] r,
  output logic          sat_hit,
  output logic          borrow,
  output logic          is_mov,
  output logic [DW-1:0] acc_inc
);

  localparam int WIDE = 2 * DW + 4;
  localparam int FSH  = DW - 1;
  localparam logic signed [WIDE-1:0] MAXV = {{(WIDE-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [WIDE-1:0] MINV = ~MAXV;

  logic signed [WIDE-1:0] aw, xw, yw;
  logic signed [WIDE-1:0] prod, frac, interp_p;
  logic                   a_ge_y;

  // Clamp a wide value into DW bits; the top bit of the return flags clamping.
  function automatic logic [DW:0] clamp(input logic signed [WIDE-1:0] v);
    if (v > MAXV)      return {1'b1, MAXV[DW-1:0]};
    else if (v < MINV) return {1'b1, MINV[DW-1:0]};
    else               return {1'b0, v[DW-1:0]};
  endfunction

  // Keep DW-1 low bits and sign-extend from the highest kept bit.
  function automatic logic [DW-1:0] wrap_short(input logic signed [WIDE-1:0] v);
    return {v[DW-2], v[DW-2:0]};
  endfunction

  assign aw       = {{(WIDE-DW){a[DW-1]}}, a};
  assign xw       = {{(WIDE-DW){x[DW-1]}}, x};
  assign yw       = {{(WIDE-DW){y[DW-1]}}, y};
  assign prod     = xw * yw;
  assign frac     = prod >>> FSH;
  assign interp_p = (xw * (yw - aw)) >>> FSH;
  assign a_ge_y   = $signed(a) >= $signed(y);
  assign acc_inc  = frac[DW-1:0];
  assign is_mov   = (op == OP_MOVACC);

  logic signed [WIDE-1:0] s_add, s_sub;
  assign s_add = aw + frac;
  assign s_sub = aw - frac;

  always_comb begin
    r       = a;
    sat_hit = 1'b0;
    borrow  = 1'b0;
    case (op)
      OP_MACF:   {sat_hit, r} = clamp(s_add);
      OP_MACFN:  {sat_hit, r} = clamp(s_sub);
      OP_MACFW:  r = s_add[DW-1:0];
      OP_MACFNW: r = s_sub[DW-1:0];
      OP_MACI:   {sat_hit, r} = clamp(aw + prod);
      OP_MACIW:  r = wrap_short(aw + prod);
      OP_ADD3:   {sat_hit, r} = clamp(aw + xw + yw);
      OP_MOVACC: r = a;
      OP_MASKX:  r = (a & x) ^ y;
      OP_TSTINV: begin r = a_ge_y ? x : ~x; borrow = !a_ge_y; end
      OP_SELGE:  begin r = a_ge_y ? x : y;  borrow = !a_ge_y; end
      OP_SELLT:  begin r = a_ge_y ? y : x;  borrow = !a_ge_y; end
      OP_INTERP: {sat_hit, r} = clamp(aw + interp_p);
      default:   r = a;
    endcase
  end

endmodule

// File: rtl/fxp_cond.sv
module fxp_cond
  import fxp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]  r,
  input  logic           sat_hit,
  input  logic           borrow,
  output logic [CCW-1:0] cc
);

  always_comb begin
    cc            = '0;
    cc[CC_NORM]   = r[DW-1] ^ r[DW-2];
    cc[CC_BORROW] = borrow;
    cc[CC_MINUS]  = r[DW-1];
    cc[CC_ZERO]   = (r == '0);
    cc[CC_SAT]    = sat_hit;
    cc[CC_NZ]     = (r != '0);
  end

endmodule

// File: rtl/fxp_accum.sv
module fxp_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] inc,
  output logic [DW-1:0] acc
);

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc + inc;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc)); // R6

endmodule

// File: rtl/fxp_sat_trk.sv
module fxp_sat_trk #(
  parameter int PCW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [PCW-1:0] pc,
  output logic           seen,
  output logic [PCW-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      pc_q <= '0;
    end else if (hit && !seen) begin
      seen <= 1'b1;
      pc_q <= pc;
    end
  end

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> (seen && $stable(pc_q))); // R11
  AST_SAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !seen) |=> (seen && pc_q == $past(pc))); // R11

endmodule

// File: rtl/fxp_dsp_alu.sv
module fxp_dsp_alu
  import fxp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_x,
  input  logic [DATA_W-1:0] op_y,
  input  logic [PC_W-1:0]   instr_pc,
  output logic [DATA_W-1:0] res,
  output logic [8:0]        cc,
  output logic              res_valid,
  output logic [DATA_W-1:0] acc,
  output logic              sat_seen,
  output logic [PC_W-1:0]   sat_pc
);

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] r_nxt, acc_inc;
  logic [CCW-1:0]    cc_nxt;
  logic              sat_hit, borrow, is_mov;
  logic              sat_event, acc_en;

  fxp_arith #(.DW(DATA_W)) u_arith (
    .op(opcode), .a(op_a), .x(op_x), .y(op_y),
    .r(r_nxt), .sat_hit(sat_hit), .borrow(borrow),
    .is_mov(is_mov), .acc_inc(acc_inc)
  );

  fxp_cond #(.DW(DATA_W)) u_cond (
    .r(r_nxt), .sat_hit(sat_hit), .borrow(borrow), .cc(cc_nxt)
  );

  assign sat_event = issue & sat_hit;
  assign acc_en    = issue & is_mov;

  fxp_accum #(.DW(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .inc(acc_inc), .acc(acc)
  );

  fxp_sat_trk #(.PCW(PC_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .hit(sat_event), .pc(instr_pc),
    .seen(sat_seen), .pc_q(sat_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      cc        <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= issue;
      if (issue) begin
        res <= r_nxt;
        cc  <= cc_nxt;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> res_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!res_valid && $stable(res) && $stable(cc))); // R1
  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cc[CC_SAT]) |-> (res == POS_LIM || res == NEG_LIM)); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((cc[CC_ZERO] == (res == '0)) && (cc[CC_NZ] != cc[CC_ZERO]))); // R10

endmodule

// File: tb/sim_fxp_dsp_alu.sv
module sim_fxp_dsp_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0, op_x = '0, op_y = '0;
  logic [8:0]  instr_pc = '0;
  logic [31:0] res, acc;
  logic [8:0]  cc, sat_pc;
  logic        res_valid, sat_seen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fxp_dsp_alu u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .op_a(op_a), .op_x(op_x), .op_y(op_y), .instr_pc(instr_pc),
    .res(res), .cc(cc), .res_valid(res_valid), .acc(acc),
    .sat_seen(sat_seen), .sat_pc(sat_pc)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a, x, y, r;
    logic        sat;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 32'h10000000, 32'h40000000, 32'h40000000, 32'h30000000, 1'b0}, // R2
    '{4'h0, 32'h7FFFFFF0, 32'h40000000, 32'h40000000, 32'h7FFFFFFF, 1'b1}, // R2
    '{4'h1, 32'h10000000, 32'h40000000, 32'h40000000, 32'hF0000000, 1'b0}, // R2
    '{4'h1, 32'h80000010, 32'h40000000, 32'h40000000, 32'h80000000, 1'b1}, // R2
    '{4'h2, 32'h7FFFFFF0, 32'h40000000, 32'h40000000, 32'h9FFFFFF0, 1'b0}, // R3
    '{4'h3, 32'h80000010, 32'h40000000, 32'h40000000, 32'h60000010, 1'b0}, // R3
    '{4'h0, 32'h00000000, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 1'b1}, // R2
    '{4'h4, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0}, // R4
    '{4'h4, 32'h00000001, 32'h00010000, 32'h00010000, 32'h7FFFFFFF, 1'b1}, // R4
    '{4'h5, 32'h3FFFFFFF, 32'h00000001, 32'h00000001, 32'hC0000000, 1'b0}, // R4
    '{4'h6, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000006, 1'b0}, // R5
    '{4'h6, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 32'h7FFFFFFF, 1'b1}, // R5
    '{4'h6, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h80000000, 1'b1}, // R5
    '{4'h8, 32'hFF00FF00, 32'h0F0F0F0F, 32'h000000FF, 32'h0F000FFF, 1'b0}, // R7
    '{4'h9, 32'h00000005, 32'h12345678, 32'h00000005, 32'h12345678, 1'b0}, // R7
    '{4'h9, 32'hFFFFFFFF, 32'h12345678, 32'h00000000, 32'hEDCBA987, 1'b0}, // R7
    '{4'hA, 32'h00000003, 32'h0000000A, 32'h00000007, 32'h00000007, 1'b0}, // R7
    '{4'hA, 32'h7FFFFFFF, 32'h00000011, 32'h80000000, 32'h00000011, 1'b0}, // R7
    '{4'hB, 32'hFFFFFFFB, 32'h00000022, 32'h00000002, 32'h00000022, 1'b0}, // R7
    '{4'hB, 32'h00000009, 32'h00000022, 32'h00000002, 32'h00000002, 1'b0}, // R7
    '{4'hE, 32'h00000000, 32'h40000000, 32'h20000000, 32'h10000000, 1'b0}, // R8
    '{4'hE, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 32'h80000000, 1'b1}, // R8
    '{4'hC, 32'hCAFEF00D, 32'h11111111, 32'h22222222, 32'hCAFEF00D, 1'b0}, // R9
    '{4'hD, 32'h00000000, 32'h40000000, 32'h40000000, 32'h00000000, 1'b0}, // R9
    '{4'hF, 32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000, 1'b0}, // R9
    '{4'h7, 32'h0BADBEEF, 32'h40000000, 32'h40000000, 32'h0BADBEEF, 1'b0}  // R6
  };

  function automatic logic [8:0] exp_cc(logic [31:0] r, logic sat, logic [3:0] op,
                                        logic [31:0] a, logic [31:0] y);
    logic [8:0] c;
    c    = '0;
    c[0] = r[31] != r[30];
    c[1] = (op >= 4'h9 && op <= 4'hB) && ($signed(a) < $signed(y));
    c[2] = r[31];
    c[3] = (r == 32'h0);
    c[4] = sat;
    c[8] = (r != 32'h0);
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run_op(logic [3:0] op, logic [31:0] a, logic [31:0] x,
                        logic [31:0] y, logic [8:0] pc);
    @(negedge clk);
    opcode = op; op_a = a; op_x = x; op_y = y; instr_pc = pc; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_acc;
    logic        e_seen;
    logic [8:0]  e_spc;
    logic [31:0] last_r;
    e_acc = '0; e_seen = 0; e_spc = '0;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 res", res, 32'h0);
    chk("R12 cc", {23'h0, cc}, 32'h0);
    chk("R12 valid", {31'h0, res_valid}, 32'h0);
    chk("R12 acc", acc, 32'h0);
    chk("R12 sat", {22'h0, sat_seen, sat_pc}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].a, VEC[i].x, VEC[i].y, 9'(i + 64));
      if (VEC[i].op == 4'h7) e_acc = e_acc + 32'h20000000;
      if (VEC[i].sat && !e_seen) begin e_seen = 1; e_spc = 9'(i + 64); end
      chk($sformatf("R2-8 vec%0d res (R9 for C/D/F)", i), res, VEC[i].r);
      chk($sformatf("R10 vec%0d cc", i), {23'h0, cc},
          {23'h0, exp_cc(VEC[i].r, VEC[i].sat, VEC[i].op, VEC[i].a, VEC[i].y)});
      chk($sformatf("R1 vec%0d valid", i), {31'h0, res_valid}, 32'h1);
      chk($sformatf("R6 vec%0d acc", i), acc, e_acc);
      chk($sformatf("R11 vec%0d sat", i), {22'h0, sat_seen, sat_pc}, {22'h0, e_seen, e_spc});
    end

    // R1: idle cycle with new operands holds results
    last_r = res;
    @(negedge clk);
    opcode = 4'h6; op_a = 32'h1; op_x = 32'h1; op_y = 32'h1;
    @(negedge clk);
    chk("R1 idle res", res, last_r);
    chk("R1 idle valid", {31'h0, res_valid}, 32'h0);

    // R6 accumulator wrap
    run_op(4'h7, 32'h5, 32'h80000000, 32'h80000000, 9'h10);
    chk("R6 acc step", acc, 32'hA0000000);
    chk("R6 mov res", res, 32'h5);
    run_op(4'h7, 32'h6, 32'h7FFFFFFF, 32'h7FFFFFFF, 9'h11);
    chk("R6 acc wrap", acc, 32'h1FFFFFFE);
    run_op(4'h0, 32'h0, 32'h40000000, 32'h40000000, 9'h12);
    chk("R6 acc untouched by 0", acc, 32'h1FFFFFFE);

    // R11: later saturation keeps the first address
    run_op(4'h6, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, 9'h1FF);
    chk("R11 sticky", {22'h0, sat_seen, sat_pc}, {22'h0, 1'b1, 9'h41});

    // R12 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R12 rerun res", res, 32'h0);
    chk("R12 rerun acc", acc, 32'h0);
    chk("R12 rerun sat", {22'h0, sat_seen, sat_pc}, 32'h0);
    rst_n = 1'b1;

    // R11 capture after reset
    run_op(4'h1, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 9'h1AB);
    chk("R2 neg clamp", res, 32'h80000000);
    chk("R11 capture", {22'h0, sat_seen, sat_pc}, {22'h0, 1'b1, 9'h1AB});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule